// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a programmable interval timer for a processor subsystem. A down-counter is stepped either straight from a selected tick source or through a free-running 5-bit divider that passes on one step for every 32 source ticks. The tick source is the local clock or an external pulse input. The external input goes through a two-stage synchronizer and an edge detector before use. Software writes a reload value as byte-wide registers and picks one of four operating modes. It starts and stops the timer with a run bit and can read the live count at any time.

Each time the counter is stepped at zero, the block raises an expiry event. The mode decides what follows. The two repeating modes reload the counter; one of them also inverts a square-wave output. The one-shot mode lets the counter wrap to all ones so that time past the expiry can still be measured. The pure counting mode wraps silently and raises no flag. A sticky expiry flag drives the interrupt request, and software clears it by writing a one.

Top module: `cd_timer24`

## Requirements
- R1: After reset every register reads zero, and `irq_o` and `tout_o` are low. Address map: 0 = control (bit0 run, bit1 divider in use, bit2 external source, bits 4:3 mode: 0 repeating flag, 1 square wave, 2 one-shot, 3 free count); 1, 2, 3 = reload value bytes from low to high; 4, 5, 6 = live count bytes from low to high; 7 = status (bit0 expiry flag).
- R2: With the divider in use, the first source tick sets the divider to 31. After that the counter moves once per 32 source ticks: on the tick that finds the divider at zero.
- R3: After the run bit goes from 0 to 1, the first source tick copies the reload value into the counter and does not decrement it. With the local clock and no divider, that tick is the clock edge after the control write.
- R4: In mode 0, a step at a count of zero sets the expiry flag, raises `irq_o` and reloads the counter. With reload value P and no divider, this happens P+2 clocks after the control write.
- R5: In mode 1, every expiry event inverts `tout_o` and reloads the counter, so the output period is twice (P+1) steps. Outside mode 1, `tout_o` is held low.
- R6: Writing 1 to status bit0 clears the expiry flag and lowers `irq_o`. Writing 0 to status leaves the flag unchanged.
- R7: While the run bit is 0, the counter and divider hold their values and the count can still be read back.
- R8: In mode 2, the expiry event sets the flag and the counter wraps to 0xFFFFFF. It keeps counting down from there and does not reload.
- R9: In mode 3, stepping at zero wraps to 0xFFFFFF and never sets the expiry flag.
- R10: With the external source selected, only rising edges of `tin_i` count as source ticks, and clock cycles without an edge leave the counter unchanged. Without the divider, the first edge loads the counter and each later edge decrements it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tin_i | input | 1 | External count input, asynchronous |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request, follows the expiry flag |
| tout_o | output | 1 | Square-wave output |

## Verification
The hardest case to reach from the ports is the divider boundary. The counter must stay frozen for 31 source ticks and move on the 32nd, and the phase is set by the first-tick load. The stimulus uses a reload value of 1 with the divider on and reads the count exactly at the 32nd and 33rd clocks after the start. It then checks the expiry on the 65th clock and that it has not happened on the 64th. The external-edge path is driven by widely spaced pulses on `tin_i`, with long idle stretches in between that show the local clock is ignored.

// File: rtl/cd_timer24_pkg.sv
package cd_timer24_pkg;
  typedef enum logic [1:0] {
    M_REPEAT  = 2'd0,
    M_SQUARE  = 2'd1,
    M_ONESHOT = 2'd2,
    M_FREE    = 2'd3
  } tmode_e;

  localparam int          AW     = 3;
  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_PRE0 = 3'd1;
  localparam logic [AW-1:0] A_CNT0 = 3'd4;
  localparam logic [AW-1:0] A_STAT = 3'd7;

  // Modes that refill the counter from the reload value on expiry
  function automatic logic mode_reloads(tmode_e m);
    return (m == M_REPEAT) || (m == M_SQUARE);
  endfunction

  // Modes that raise the expiry flag
  function automatic logic mode_flags(tmode_e m);
    return m != M_FREE;
  endfunction
endpackage

// File: rtl/cd_timer24_sync.sv
module cd_timer24_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/cd_timer24_psc.sv
module cd_timer24_psc #(
  parameter int PSC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_i,
  input  logic             src_tick_i,
  input  logic             load_i,
  output logic             step_o,
  output logic [PSC_W-1:0] psc_o
);
  logic [PSC_W-1:0] psc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  psc_q <= '0;
    else if (load_i)             psc_q <= '1;
    else if (use_i && src_tick_i) psc_q <= psc_q - 1'b1;  // wraps 0 -> all ones
  end

  assign step_o = src_tick_i && (!use_i || psc_q == '0);
  assign psc_o  = psc_q;
endmodule

// File: rtl/cd_timer24_cnt.sv
module cd_timer24_cnt
  import cd_timer24_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  tmode_e           mode_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_evt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign zero_evt_o = step_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt_q <= '0;
    else if (load_i)                           cnt_q <= reload_i;
    else if (zero_evt_o && mode_reloads(mode_i)) cnt_q <= reload_i;
    else if (step_i)                           cnt_q <= cnt_q - 1'b1;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/cd_timer24.sv
module cd_timer24
  import cd_timer24_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int PSC_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tin_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        irq_o,
  output logic        tout_o
);
  localparam int NB = CNT_W / 8;

  logic [4:0]       ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             flag_q;
  logic             tout_q;
  logic             pend_q;

  logic             run_w, use_psc_w, ext_w;
  tmode_e           mode_e;
  logic [1:0]       mode_w;
  logic             tin_rise_w, src_tick_w, load_evt_w, cnt_tick_w, step_w, zero_evt_w;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] count_w;
  logic             wr_ctrl_w, wr_stat_w;

  assign run_w     = ctrl_q[0];
  assign use_psc_w = ctrl_q[1];
  assign ext_w     = ctrl_q[2];
  assign mode_w    = ctrl_q[4:3];
  assign mode_e    = tmode_e'(mode_w);
  assign wr_ctrl_w = we_i && (addr_i == A_CTRL);
  assign wr_stat_w = we_i && (addr_i == A_STAT);

  cd_timer24_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(tin_i), .rise_o(tin_rise_w)
  );

  assign src_tick_w = run_w && (ext_w ? tin_rise_w : 1'b1);
  assign load_evt_w = src_tick_w && pend_q;

  cd_timer24_psc #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .use_i(use_psc_w), .src_tick_i(src_tick_w),
    .load_i(load_evt_w), .step_o(cnt_tick_w), .psc_o(psc_q)
  );

  assign step_w = cnt_tick_w && !pend_q;

  cd_timer24_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(load_evt_w), .step_i(step_w),
    .mode_i(mode_e), .reload_i(reload_q), .count_o(count_w), .zero_evt_o(zero_evt_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      pend_q   <= 1'b0;
      flag_q   <= 1'b0;
      tout_q   <= 1'b0;
    end else begin
      if (wr_ctrl_w) ctrl_q <= wdata_i[4:0];
      for (int k = 0; k < NB; k++) begin
        if (we_i && (addr_i == AW'(int'(A_PRE0) + k))) reload_q[8*k +: 8] <= wdata_i;
      end
      if (wr_ctrl_w && wdata_i[0] && !run_w) pend_q <= 1'b1;
      else if (load_evt_w)                   pend_q <= 1'b0;
      if (zero_evt_w && mode_flags(mode_e))  flag_q <= 1'b1;
      else if (wr_stat_w && wdata_i[0])      flag_q <= 1'b0;
      if (mode_e != M_SQUARE)                tout_q <= 1'b0;
      else if (zero_evt_w)                   tout_q <= ~tout_q;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == A_CTRL) rdata_o = {3'b000, ctrl_q};
    if (addr_i == A_STAT) rdata_o = {7'b0, flag_q};
    for (int k = 0; k < NB; k++) begin
      if (addr_i == AW'(int'(A_PRE0) + k)) rdata_o = reload_q[8*k +: 8];
      if (addr_i == AW'(int'(A_CNT0) + k)) rdata_o = count_w[8*k +: 8];
    end
  end

  assign irq_o  = flag_q;
  assign tout_o = tout_q;
endmodule

// File: rtl/cd_timer24_chk.sv
module cd_timer24_chk #(
  parameter int CNT_W = 24,
  parameter int PSC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             use_psc,
  input logic             pend,
  input logic [1:0]       mode,
  input logic [PSC_W-1:0] psc,
  input logic [CNT_W-1:0] count,
  input logic             zero_evt,
  input logic             flag,
  input logic             we,
  input logic [2:0]       addr,
  input logic [7:0]       wdata,
  input logic             irq,
  input logic             tout
);
  // R2: between divider wraps the counter does not move
  assert_hold_between_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && use_psc && !pend && psc != '0) |=> $stable(count));

  // R4: expiry in a flagging mode raises the interrupt
  assert_flag_on_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && mode != 2'd3) |=> irq);

  // R5: square-wave output inverts on expiry
  assert_tout_toggles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && mode == 2'd1 && !(we && addr == 3'd0)) |=> (tout != $past(tout)));

  // R6: a write of one to status clears the request
  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 3'd7 && wdata[0] && !zero_evt) |=> !irq);

  // R7: halted timer keeps its count
  assert_halt_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));

  // R8: one-shot and free count wrap to all ones
  assert_wrap_all_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && mode[1]) |=> (&count));

  // R9: free count never raises the flag
  assert_free_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !flag && !(we && addr == 3'd0)) |=> !flag);
endmodule

bind cd_timer24 cd_timer24_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_w), .use_psc(use_psc_w), .pend(pend_q),
  .mode(mode_w), .psc(psc_q), .count(count_w), .zero_evt(zero_evt_w),
  .flag(flag_q), .we(we_i), .addr(addr_i), .wdata(wdata_i), .irq(irq_o), .tout(tout_o)
);

// File: tb/cd_timer24_bench.sv
module cd_timer24_bench;
  timeunit 1ns;
  timeprecision 10ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tin = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, tout;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    int         kind;   // 0 read data, 1 irq, 2 tout
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  cd_timer24 u_cd_timer24 (
    .clk(clk), .rst_n(rst_n), .tin_i(tin), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .tout_o(tout)
  );

  // Monitor: pops expected items and compares against the design
  initial begin
    forever begin
      wait (sb.size() > 0);
      #0.1;
      begin
        item_t it;
        logic [7:0] act;
        it = sb.pop_front();
        act = (it.kind == 0) ? rdata : (it.kind == 1) ? {7'b0, irq} : {7'b0, tout};
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic exp_rd(input logic [2:0] a, input logic [7:0] e, input string r);
    item_t it;
    addr = a;
    it.kind = 0; it.exp = e; it.req = r;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic exp_pin(input int k, input logic v, input string r);
    item_t it;
    it.kind = k; it.exp = {7'b0, v}; it.req = r;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse();
    tin = 1'b1;
    repeat (4) @(negedge clk);
    tin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    exp_rd(3'd0, 8'h00, "R1 ctrl");
    exp_rd(3'd4, 8'h00, "R1 count");
    exp_rd(3'd7, 8'h00, "R1 status");
    exp_pin(1, 1'b0, "R1 irq");
    exp_pin(2, 1'b0, "R1 tout");

    // Repeating mode, local clock, no divider, reload 3
    wr(3'd1, 8'h03); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd0, 8'h01);
    idle(1); exp_rd(3'd4, 8'h03, "R3 first tick loads");
    idle(1); exp_rd(3'd4, 8'h02, "R3 then decrements");
    idle(2); exp_pin(1, 1'b0, "R4 not yet expired");
    idle(1); exp_pin(1, 1'b1, "R4 expiry at P+2");
    exp_rd(3'd4, 8'h03, "R4 reload after expiry");
    wr(3'd7, 8'h00); exp_pin(1, 1'b1, "R6 zero write keeps flag");
    wr(3'd7, 8'h01); exp_pin(1, 1'b0, "R6 one write clears flag");
    wr(3'd0, 8'h00);
    exp_rd(3'd4, 8'h00, "R7 halted count");
    idle(10);
    exp_rd(3'd4, 8'h00, "R7 count held");
    exp_pin(1, 1'b0, "R7 no expiry while halted");

    // Divider in use, reload 1
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h03);
    idle(32); exp_rd(3'd4, 8'h01, "R2 held for 32 ticks");
    idle(1);  exp_rd(3'd4, 8'h00, "R2 step on divider wrap");
    idle(31); exp_pin(1, 1'b0, "R2 no early expiry");
    idle(1);  exp_pin(1, 1'b1, "R2 expiry at 65");
    wr(3'd0, 8'h00); wr(3'd7, 8'h01);

    // Square wave, reload 2
    wr(3'd1, 8'h02);
    wr(3'd0, 8'h09);
    idle(3); exp_pin(2, 1'b0, "R5 low before expiry");
    idle(1); exp_pin(2, 1'b1, "R5 toggles high");
    idle(2); exp_pin(2, 1'b1, "R5 holds");
    idle(1); exp_pin(2, 1'b0, "R5 toggles low");
    wr(3'd0, 8'h00); wr(3'd7, 8'h01);
    exp_pin(2, 1'b0, "R5 low outside square mode");

    // One-shot, reload 2
    wr(3'd0, 8'h11);
    idle(4); exp_rd(3'd6, 8'hFF, "R8 wraps to all ones");
    exp_pin(1, 1'b1, "R8 flag set");
    idle(2); exp_rd(3'd4, 8'hFD, "R8 keeps counting low");
    exp_rd(3'd5, 8'hFF, "R8 keeps counting mid");
    wr(3'd0, 8'h00); wr(3'd7, 8'h01);

    // Free count, reload 1
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h19);
    idle(3); exp_rd(3'd6, 8'hFF, "R9 wraps high");
    exp_rd(3'd4, 8'hFF, "R9 wraps low");
    exp_pin(1, 1'b0, "R9 no flag");
    idle(1); exp_rd(3'd4, 8'hFE, "R9 keeps counting");
    exp_pin(1, 1'b0, "R9 still no flag");
    wr(3'd0, 8'h00);   // step on this edge leaves 0xFFFFFD

    // External source, no divider, reload 5
    wr(3'd1, 8'h05);
    wr(3'd0, 8'h05);
    idle(10); exp_rd(3'd4, 8'hFD, "R10 clock alone does nothing");
    pulse(); pulse(); pulse();
    exp_rd(3'd4, 8'h03, "R10 load then two steps");
    idle(20); exp_rd(3'd4, 8'h03, "R10 idle stretch held");
    pulse(); pulse(); pulse();
    exp_rd(3'd4, 8'h00, "R10 reaches zero");
    exp_pin(1, 1'b0, "R10 no expiry yet");
    pulse();
    exp_rd(3'd4, 8'h05, "R10 reload on edge");
    exp_pin(1, 1'b1, "R10 expiry on edge");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule